// File: doc/BRIEF.md
# Multi-Channel Down-Counting Timer Bank

This block provides three independent 32-bit countdown channels behind a small word-addressed register port. Each channel keeps a start value and a live count. When enabled, the count steps down once per prescaled tick. Reaching zero raises that channel's flag in a shared status word. A shared mask word selects which flags drive the single interrupt line.

A channel runs in one of two modes. In continuous mode it wraps back to its start value and keeps going. In single-shot mode it turns itself off at zero. Software can force the start value into the count at any time through a reload request in the control word.

The timebase is an external tick-enable strobe that stands in for the selected clock source. The two-bit source field is only stored. Software clears flags by writing ones to the status word. A rising count can be derived by subtracting the live count from all-ones; a start value of all-ones gives a free-running wrap counter.

Top module: `timer_bank`

## Requirements
- R1: After reset every register reads 0 and `irq` is low.
- R2: Address map, with the low nibble of the address matching exactly: interrupt mask at 0x00 and status at 0x04, where bit n belongs to channel n. Channel n (n < NUM_CH) has its control word at 0x10+0x10*n, start value at 0x14+0x10*n and live count at 0x18+0x10*n. Mask bits at and above NUM_CH read 0. Any other address reads 0, and writes to it change nothing.
- R3: Control word layout: bit 0 enable; bit 1 reload request; bits 3:2 source select, stored and read back only; bits 6:4 prescale exponent k; bit 7 single-shot when 1, continuous when 0. Bits 31:8 read 0.
- R4: A control write with bit 1 set copies the start value into the count at the next clock edge, whether or not the channel is enabled. Bit 1 reads back 0 after that copy.
- R5: While enabled, the count drops by one on each prescaled step. While disabled, the count holds.
- R6: With exponent k, a step occurs once every 2^k cycles in which `tickEn` is high while enabled. The first step occurs on the 2^k-th such cycle after enabling.
- R7: A step that takes the count from 1 to 0 sets the channel's status bit. A step taken while the count is 0 loads the start value.
- R8: In single-shot mode, the step that reaches 0 also clears the enable bit, so the count stays at 0.
- R9: Writing 1 to a status bit clears it; writing 0 leaves it unchanged.
- R10: `irq` is high exactly when some status bit is set and its mask bit is also set.
- R11: Writing the start value does not alter a running count until a reload request or a wrap at zero.
- R12: The live count register is read-only. A start value of 0xFFFFFFFF loads as 0xFFFFFFFF and steps to 0xFFFFFFFE.
- R13: Channels count, flag and reload independently of each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tickEn | input | 1 | Timebase strobe standing in for the selected source |
| wrEn | input | 1 | Write strobe for the register port |
| addr | input | 8 | Byte address of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, combinational from `addr` |
| irq | output | 1 | Masked OR of the status flags |

## Verification
The bench builds the block with its default of three channels. This makes channel index 3 an unmapped page, so the address-range rejection can be exercised. With 32-bit counts, wraps are only observed from small start values. The all-ones case is reached by checking the load value and the first step after it. A prescale exponent of 2 keeps the divided step within a handful of ticks while still showing where the first step lands.

// File: rtl/timer_bank_pkg.sv
package timer_bank_pkg;
  localparam int DATA_W   = 32;
  localparam int ADDR_W   = 8;
  localparam int CH_IDX_W = ADDR_W - 4;
  localparam int PRE_W    = 7;

  localparam logic [3:0] OFF_MASK = 4'h0;
  localparam logic [3:0] OFF_STAT = 4'h4;
  localparam logic [3:0] OFF_CTRL = 4'h0;
  localparam logic [3:0] OFF_INTV = 4'h4;
  localparam logic [3:0] OFF_CUR  = 4'h8;

  typedef enum logic [2:0] {
    RD_NONE, RD_MASK, RD_STAT, RD_CTRL, RD_INTV, RD_CUR
  } rdKind_e;

  typedef struct packed {
    logic                wrMask;
    logic                wrStat;
    logic                wrCtrl;
    logic                wrIntv;
    logic [CH_IDX_W-1:0] chSel;
    rdKind_e             rdKind;
  } strobes_t;
endpackage

// File: rtl/timer_bank_ctrl.sv
module timer_bank_ctrl
  import timer_bank_pkg::*;
#(
  parameter int NUM_CH = 3
) (
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  output strobes_t          stb
);
  logic [CH_IDX_W-1:0] page;
  logic [3:0]          off;
  logic [CH_IDX_W-1:0] chIdx;
  logic                chHit;

  assign page  = addr[ADDR_W-1:4];
  assign off   = addr[3:0];
  assign chIdx = page - CH_IDX_W'(1);
  assign chHit = (page != '0) && (chIdx < CH_IDX_W'(NUM_CH));

  always_comb begin
    stb        = '0;
    stb.rdKind = RD_NONE;
    stb.chSel  = chIdx;
    if (page == '0) begin
      case (off)
        OFF_MASK: begin stb.rdKind = RD_MASK; stb.wrMask = wrEn; end
        OFF_STAT: begin stb.rdKind = RD_STAT; stb.wrStat = wrEn; end
        default:  stb.rdKind = RD_NONE;
      endcase
    end else if (chHit) begin
      case (off)
        OFF_CTRL: begin stb.rdKind = RD_CTRL; stb.wrCtrl = wrEn; end
        OFF_INTV: begin stb.rdKind = RD_INTV; stb.wrIntv = wrEn; end
        OFF_CUR:  stb.rdKind = RD_CUR;
        default:  stb.rdKind = RD_NONE;
      endcase
    end
  end
endmodule

// File: rtl/timer_bank_dp.sv
module timer_bank_dp
  import timer_bank_pkg::*;
#(
  parameter int NUM_CH = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickEn,
  input  strobes_t          stb,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic [NUM_CH-1:0] statusVec,
  output logic [NUM_CH-1:0] maskVec
);
  logic [DATA_W-1:0] ctrlArr [NUM_CH];
  logic [DATA_W-1:0] intvArr [NUM_CH];
  logic [DATA_W-1:0] cntArr  [NUM_CH];
  logic [NUM_CH-1:0] expVec;

  for (genvar g = 0; g < NUM_CH; g++) begin : gCh
    logic              en, rld, oneShot;
    logic [1:0]        src;
    logic [2:0]        presc;
    logic [DATA_W-1:0] intv, cnt;
    logic [PRE_W-1:0]  pre, mask;
    logic              sel, step, expire;

    assign sel    = (stb.chSel == CH_IDX_W'(g));
    assign mask   = PRE_W'((8'd1 << presc) - 8'd1);
    assign step   = en & tickEn & ((pre & mask) == mask);
    assign expire = step & ~rld & (cnt == DATA_W'(1));

    always_ff @(posedge clk) begin
      if (!rstN) begin
        en <= 1'b0; rld <= 1'b0; oneShot <= 1'b0;
        src <= '0; presc <= '0; intv <= '0; cnt <= '0; pre <= '0;
      end else begin
        if (rld) begin
          cnt <= intv;
          rld <= 1'b0;
        end else if (step) begin
          cnt <= (cnt == '0) ? intv : cnt - DATA_W'(1);
        end
        if (en && tickEn) pre <= pre + PRE_W'(1);
        else if (!en)     pre <= '0;
        if (expire && oneShot) en <= 1'b0;
        if (stb.wrCtrl && sel) begin
          en      <= wdata[0];
          rld     <= wdata[1];
          src     <= wdata[3:2];
          presc   <= wdata[6:4];
          oneShot <= wdata[7];
        end
        if (stb.wrIntv && sel) intv <= wdata;
      end
    end

    assign ctrlArr[g] = {{(DATA_W-8){1'b0}}, oneShot, presc, src, rld, en};
    assign intvArr[g] = intv;
    assign cntArr[g]  = cnt;
    assign expVec[g]  = expire;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      statusVec <= '0;
      maskVec   <= '0;
    end else begin
      statusVec <= (statusVec & ~(stb.wrStat ? wdata[NUM_CH-1:0] : '0)) | expVec;
      if (stb.wrMask) maskVec <= wdata[NUM_CH-1:0];
    end
  end

  always_comb begin
    rdata = '0;
    case (stb.rdKind)
      RD_MASK: rdata = DATA_W'(maskVec);
      RD_STAT: rdata = DATA_W'(statusVec);
      default: begin
        for (int i = 0; i < NUM_CH; i++) begin
          if (stb.chSel == CH_IDX_W'(i)) begin
            if (stb.rdKind == RD_CTRL) rdata = ctrlArr[i];
            if (stb.rdKind == RD_INTV) rdata = intvArr[i];
            if (stb.rdKind == RD_CUR)  rdata = cntArr[i];
          end
        end
      end
    endcase
  end
endmodule

// File: rtl/timer_bank.sv
module timer_bank
  import timer_bank_pkg::*;
#(
  parameter int NUM_CH = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickEn,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              irq
);
  strobes_t          stb;
  logic [NUM_CH-1:0] statusVec;
  logic [NUM_CH-1:0] maskVec;

  timer_bank_ctrl #(.NUM_CH(NUM_CH)) uCtrl (
    .wrEn(wrEn), .addr(addr), .stb(stb)
  );

  timer_bank_dp #(.NUM_CH(NUM_CH)) uDp (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .stb(stb), .wdata(wdata),
    .rdata(rdata), .statusVec(statusVec), .maskVec(maskVec)
  );

  assign irq = |(statusVec & maskVec);
endmodule

// File: rtl/timer_bank_chk.sv
module timer_bank_chk
  import timer_bank_pkg::*;
#(
  parameter int NUM_CH = 3
) (
  input logic              clk,
  input logic              rstN,
  input logic              tickEn,
  input logic              wrEn,
  input logic [DATA_W-1:0] wdata,
  input logic              irq,
  input strobes_t          stb,
  input logic [NUM_CH-1:0] statusVec,
  input logic [NUM_CH-1:0] maskVec
);
  // R2: at most one write target decoded per cycle
  a_r2_one_target: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb.wrMask, stb.wrStat, stb.wrCtrl, stb.wrIntv}));

  // R2: no write strobe without a bus write
  a_r2_write_needs_wren: assert property (@(posedge clk) disable iff (!rstN)
    (stb.wrMask | stb.wrStat | stb.wrCtrl | stb.wrIntv) |-> wrEn);

  // R2: the mask word changes only through its own write
  a_r2_mask_only_by_write: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(maskVec) |-> $past(stb.wrMask));

  // R9: a flag can only drop after a status write
  a_r9_clear_needs_write: assert property (@(posedge clk) disable iff (!rstN)
    (|($past(statusVec) & ~statusVec)) |-> $past(stb.wrStat));

  // R7: a flag can only rise after a tick
  a_r7_set_needs_tick: assert property (@(posedge clk) disable iff (!rstN)
    (|(statusVec & ~$past(statusVec))) |-> $past(tickEn));

  // R10: an all-zero mask silences the interrupt line
  a_r10_zero_mask_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (stb.wrMask && wdata[NUM_CH-1:0] == '0) |=> !irq);
endmodule

bind timer_bank timer_bank_chk #(.NUM_CH(NUM_CH)) uChk (
  .clk(clk), .rstN(rstN), .tickEn(tickEn), .wrEn(wrEn), .wdata(wdata),
  .irq(irq), .stb(stb), .statusVec(statusVec), .maskVec(maskVec)
);

// File: tb/sim_timer_bank.sv
module sim_timer_bank;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        tickEn = 1'b0;
  logic        wrEn = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;

  int nChecks = 0;
  int nFails  = 0;
  int cycles  = 0;

  timer_bank #(.NUM_CH(3)) u0 (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .wrEn(wrEn),
    .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq)
  );

  always #5 clk = ~clk;

  typedef struct packed {
    logic        isWr;
    logic [7:0]  a;
    logic [31:0] d;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 20;
  // reads expect d; writes drive d
  localparam vec_t VECS [NV] = '{
    '{1'b1, 8'h00, 32'h0000_00FF, 4'd2},   // R2 mask holds NUM_CH bits
    '{1'b0, 8'h00, 32'h0000_0007, 4'd2},
    '{1'b1, 8'h24, 32'h0000_1234, 4'd2},   // R2 ch1 start value
    '{1'b0, 8'h24, 32'h0000_1234, 4'd2},
    '{1'b1, 8'h20, 32'hFFFF_FFF4, 4'd3},   // R3 fields, upper bits dropped
    '{1'b0, 8'h20, 32'h0000_00F4, 4'd3},
    '{1'b0, 8'h28, 32'h0000_0000, 4'd4},   // R4 no reload requested yet
    '{1'b1, 8'h28, 32'h0000_0055, 4'd12},  // R12 count is read-only
    '{1'b0, 8'h28, 32'h0000_0000, 4'd12},
    '{1'b1, 8'h48, 32'h0000_00FF, 4'd2},   // R2 channel 3 not mapped
    '{1'b0, 8'h48, 32'h0000_0000, 4'd2},
    '{1'b1, 8'h0C, 32'h0000_0012, 4'd2},   // R2 unused offset
    '{1'b0, 8'h0C, 32'h0000_0000, 4'd2},
    '{1'b1, 8'h34, 32'hA5A5_A5A5, 4'd2},   // R2 ch2 start value
    '{1'b0, 8'h34, 32'hA5A5_A5A5, 4'd2},
    '{1'b0, 8'h24, 32'h0000_1234, 4'd13},  // R13 ch1 untouched by ch2
    '{1'b1, 8'h20, 32'h0000_0000, 4'd3},
    '{1'b0, 8'h20, 32'h0000_0000, 4'd3},
    '{1'b1, 8'h00, 32'h0000_0000, 4'd2},
    '{1'b0, 8'h00, 32'h0000_0000, 4'd2}
  };

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    nChecks++;
    if (got !== exp) begin
      nFails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    wrEn = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a;
    #2 d = rdata;
  endtask

  task automatic rdChk(input string req, input logic [7:0] a, input logic [31:0] exp);
    logic [31:0] v;
    rd(a, v);
    check(req, v, exp);
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      tickEn = 1'b1;
      @(negedge clk);
      tickEn = 1'b0;
    end
  endtask

  task automatic finishRun();
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 20000) begin
        nChecks++; nFails++;
        $display("FAIL watchdog: got %0d cycles expected fewer", cycles);
        finishRun();
      end
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1'b1;

    // R1 reset state
    rdChk("R1 mask", 8'h00, 0);
    rdChk("R1 status", 8'h04, 0);
    rdChk("R1 ctrl0", 8'h10, 0);
    rdChk("R1 intv0", 8'h14, 0);
    rdChk("R1 cur0", 8'h18, 0);
    check("R1 irq", 32'(irq), 0);

    for (int i = 0; i < NV; i++) begin
      if (VECS[i].isWr) wr(VECS[i].a, VECS[i].d);
      else begin
        logic [31:0] v;
        rd(VECS[i].a, v);
        check($sformatf("R%0d table %0d", VECS[i].req, i), v, VECS[i].d);
      end
    end

    // R4 reload while disabled
    wr(8'h14, 5);
    wr(8'h10, 32'h02);
    rdChk("R4 count loaded", 8'h18, 5);
    rdChk("R4 reload bit cleared", 8'h10, 0);
    tick(3);
    rdChk("R5 holds while disabled", 8'h18, 5);

    // R5 / R7 continuous counting and wrap
    wr(8'h10, 32'h01);
    tick(1);
    rdChk("R5 first step", 8'h18, 4);
    tick(3);
    rdChk("R5 down to one", 8'h18, 1);
    rdChk("R7 no flag before zero", 8'h04, 0);
    tick(1);
    rdChk("R7 reached zero", 8'h18, 0);
    rdChk("R7 flag set", 8'h04, 1);
    rdChk("R7 still enabled", 8'h10, 1);
    check("R10 masked off", 32'(irq), 0);
    wr(8'h00, 1);
    #1 check("R10 irq with mask", 32'(irq), 1);
    tick(1);
    rdChk("R7 wrap loads start", 8'h18, 5);
    tick(1);
    rdChk("R7 after wrap", 8'h18, 4);

    // R9 write-one-to-clear
    wr(8'h04, 0);
    rdChk("R9 zero write keeps flag", 8'h04, 1);
    wr(8'h04, 1);
    rdChk("R9 one write clears", 8'h04, 0);
    #1 check("R10 irq drops", 32'(irq), 0);

    // R11 start write does not disturb count
    wr(8'h14, 9);
    rdChk("R11 count unchanged", 8'h18, 4);
    tick(4);
    rdChk("R11 reached zero", 8'h18, 0);
    tick(1);
    rdChk("R11 new start on wrap", 8'h18, 9);
    wr(8'h10, 0);
    wr(8'h04, 1);
    wr(8'h00, 0);

    // R8 single-shot
    wr(8'h14, 2);
    wr(8'h10, 32'h82);
    rdChk("R8 loaded", 8'h18, 2);
    wr(8'h10, 32'h81);
    tick(2);
    rdChk("R8 zero", 8'h18, 0);
    rdChk("R8 enable cleared", 8'h10, 32'h80);
    rdChk("R8 flag", 8'h04, 1);
    tick(2);
    rdChk("R8 stays at zero", 8'h18, 0);
    wr(8'h04, 1);

    // R6 prescale by 4
    wr(8'h14, 3);
    wr(8'h10, 32'h22);
    wr(8'h10, 32'h21);
    tick(3);
    rdChk("R6 no step before 4th tick", 8'h18, 3);
    tick(1);
    rdChk("R6 step on 4th tick", 8'h18, 2);
    tick(4);
    rdChk("R6 second step", 8'h18, 1);
    wr(8'h10, 0);

    // R12 all-ones start
    wr(8'h14, 32'hFFFF_FFFF);
    wr(8'h10, 32'h02);
    rdChk("R12 all-ones load", 8'h18, 32'hFFFF_FFFF);
    wr(8'h10, 32'h01);
    tick(1);
    rdChk("R12 first step", 8'h18, 32'hFFFF_FFFE);
    wr(8'h10, 0);

    // R13 channel 2 alone
    wr(8'h34, 1);
    wr(8'h30, 32'h02);
    rdChk("R13 ch2 loaded", 8'h38, 1);
    wr(8'h00, 4);
    wr(8'h30, 32'h01);
    tick(1);
    rdChk("R13 ch2 zero", 8'h38, 0);
    rdChk("R13 only ch2 flag", 8'h04, 4);
    #1 check("R13 irq from ch2", 32'(irq), 1);
    rdChk("R13 ch0 untouched", 8'h18, 32'hFFFF_FFFE);
    wr(8'h04, 4);
    #1 check("R9 ch2 cleared", 32'(irq), 0);

    finishRun();
  end
endmodule